// File: doc/BRIEF.md
# Fixed-Point Frequency Ratio Calculator

This block works out the ratio of two frequencies as an unsigned fixed-point word, using a restoring divider that produces one quotient bit per clock. It has two jobs when a programmable oscillator is being retuned. In the first, it takes a target oscillator frequency and a crystal frequency and returns the multiplier the oscillator core needs. In the second, it recovers the true crystal frequency. For this it takes a multiplier read back from the part, the output frequency that multiplier produced, and the two output divider values that were in use.

The result word has 38 bits: 10 integer bits above 28 fraction bits. Bits that fall below the last fraction bit are dropped. A caller loads the operands, pulses `start`, and collects `result` when `done` pulses. A divisor of zero, or a quotient too large for the word, is reported with a flag next to a fixed result value. Choosing the dividers and moving data over a bus are outside this block.

Top module: `freq_ratio_calc`

## Requirements
- R1: The result is an unsigned 38-bit value. Bits 37:28 are the integer part and bits 27:0 are the fraction times 2^28, truncated toward zero. A ratio of 43.54587216 (4354587216 over 100000000) yields 0x02B8BBE472.
- R2: With `mode` = 0, the result is floor(`a_freq` * 2^28 / `b_freq`). This is the new multiplier, computed from the oscillator frequency over the crystal frequency.
- R3: With `mode` = 1, the result is floor(`a_freq` * `old_hs` * `old_n1` * 2^28 / `old_mult`). This is the crystal frequency as an integer, in the same units as `a_freq`.
- R4: When `start` is accepted at a clock edge, `busy` is high from the next cycle onward. `done` goes high for exactly one cycle, 38 clock edges after the accepting edge, with `busy` low in that same cycle.
- R5: If the exact quotient is 2^38 or more, `overflow` is 1 and `result` is all ones. A quotient of 2^38 - 1 or less sets no overflow.
- R6: If the selected divisor is zero, `div_zero` is 1, `overflow` is 0 and `result` is zero.
- R7: A `start` that arrives while `busy` is high is ignored and produces no extra `done`. Operands are captured at the accepting edge, so changing them afterwards does not affect the result.
- R8: `result`, `overflow` and `div_zero` change only in a cycle where `done` is high, and they hold between completions.
- R9: After reset, `busy`, `done`, `overflow` and `div_zero` are 0 and `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a calculation when idle |
| mode | input | 1 | 0: new multiplier, 1: crystal recovery |
| a_freq | input | FW (36) | Oscillator frequency (mode 0) or old output frequency (mode 1) |
| b_freq | input | FW (36) | Crystal frequency (mode 0) |
| old_mult | input | RW (38) | Read-back multiplier in 10.28 form (mode 1) |
| old_hs | input | HS_W (4) | Old high-speed divider value (mode 1) |
| old_n1 | input | N1_W (7) | Old second divider value (mode 1) |
| busy | output | 1 | Calculation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | RW (38) | Quotient word |
| overflow | output | 1 | Quotient saturated |
| div_zero | output | 1 | Divisor was zero |

## Verification
Every result, including the overflow and zero-divisor cases, appears together with its flags exactly 38 clock edges after the edge that accepts `start`. The driver records the cycle number at which it raises `start` and queues the expected word with a due cycle one edge plus 38 edges later. The monitor samples on falling edges and checks that each `done` arrives in exactly its due cycle. It treats any `done` with nothing queued as a failure, which is how an ignored mid-run `start` is checked.

// File: rtl/freq_ratio_calc.sv
module freq_ratio_calc #(
  parameter int FW   = 36,
  parameter int HS_W = 4,
  parameter int N1_W = 7,
  parameter int RW   = 38,
  parameter int FRAC = 28
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            mode,
  input  logic [FW-1:0]   a_freq,
  input  logic [FW-1:0]   b_freq,
  input  logic [RW-1:0]   old_mult,
  input  logic [HS_W-1:0] old_hs,
  input  logic [N1_W-1:0] old_n1,
  output logic            busy,
  output logic            done,
  output logic [RW-1:0]   result,
  output logic            overflow,
  output logic            div_zero
);
  localparam int INT = RW - FRAC;
  localparam int NW  = FW + HS_W + N1_W;
  localparam int CW  = $clog2(RW + 1);

  logic [NW-1:0] num_w, den_w, num_hi;
  logic [NW-1:0] rem, den_r, trial;
  logic [RW-1:0] sh;
  logic [CW-1:0] cnt;
  logic          take, ovf_p, zero_p;

  assign num_w  = mode ? NW'(a_freq) * NW'(old_hs) * NW'(old_n1) : NW'(a_freq);
  assign den_w  = mode ? NW'(old_mult) : NW'(b_freq);
  assign num_hi = num_w >> INT;
  assign trial  = {rem[NW-2:0], sh[RW-1]};
  assign take   = trial >= den_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      result   <= '0;
      overflow <= 1'b0;
      div_zero <= 1'b0;
      rem      <= '0;
      den_r    <= '0;
      sh       <= '0;
      cnt      <= '0;
      ovf_p    <= 1'b0;
      zero_p   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!busy && start) begin
        busy   <= 1'b1;
        cnt    <= CW'(RW);
        rem    <= num_hi;
        sh     <= {num_w[INT-1:0], {FRAC{1'b0}}};
        den_r  <= den_w;
        zero_p <= (den_w == '0);
        ovf_p  <= (den_w != '0) && (num_hi >= den_w);
      end else if (busy) begin
        rem <= take ? trial - den_r : trial;
        sh  <= {sh[RW-2:0], take};
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          overflow <= ovf_p;
          div_zero <= zero_p;
          result   <= zero_p ? '0 : (ovf_p ? '1 : {sh[RW-2:0], take});
        end
      end
    end
  end
endmodule

// File: rtl/freq_ratio_calc_chk.sv
module freq_ratio_calc_chk #(
  parameter int RW = 38
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [RW-1:0] result,
  input logic          overflow,
  input logic          div_zero
);
  localparam int LW = $clog2(RW + 1) + 1;
  logic [LW-1:0] lat;

  always_ff @(posedge clk) begin
    if (!rst_n)              lat <= '0;
    else if (start && !busy) lat <= '0;
    else if (busy)           lat <= lat + LW'(1);
  end

  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> lat == LW'(RW)); // R4
  AST_DONE_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R4
  AST_DONE_IDLE:    assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R4
  AST_SATURATE:     assert property (@(posedge clk) disable iff (!rst_n) (done && overflow) |-> result == '1); // R5
  AST_ZERO_DIV:     assert property (@(posedge clk) disable iff (!rst_n) (done && div_zero) |-> (result == '0 && !overflow)); // R6
  AST_NO_RESTART:   assert property (@(posedge clk) disable iff (!rst_n) busy |=> (busy || done)); // R7
  AST_RESULT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n) !done |-> ($stable(result) && $stable(overflow) && $stable(div_zero))); // R8
endmodule

bind freq_ratio_calc freq_ratio_calc_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .result(result), .overflow(overflow), .div_zero(div_zero)
);

// File: tb/freq_ratio_calc_tb.sv
`timescale 1ns/1ps
module freq_ratio_calc_tb;
  localparam int FW = 36, HS_W = 4, N1_W = 7, RW = 38, FRAC = 28;

  logic clk = 0, rst_n = 0, start = 0, mode = 0;
  logic [FW-1:0] a_freq = '0, b_freq = '0;
  logic [RW-1:0] old_mult = '0;
  logic [HS_W-1:0] old_hs = '0;
  logic [N1_W-1:0] old_n1 = '0;
  logic busy, done, overflow, div_zero;
  logic [RW-1:0] result;

  int checks = 0, fails = 0;
  longint cyc = 0;
  bit finished = 0;

  logic [RW-1:0] q_res[$];
  logic [1:0]    q_flg[$];
  longint        q_due[$];
  string         q_req[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  freq_ratio_calc #(.FW(FW), .HS_W(HS_W), .N1_W(N1_W), .RW(RW), .FRAC(FRAC)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .a_freq(a_freq), .b_freq(b_freq),
    .old_mult(old_mult), .old_hs(old_hs), .old_n1(old_n1), .busy(busy), .done(done),
    .result(result), .overflow(overflow), .div_zero(div_zero));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input string req, input logic m, input logic [FW-1:0] a, input logic [FW-1:0] b,
                     input logic [RW-1:0] mult, input logic [HS_W-1:0] hs, input logic [N1_W-1:0] n1);
    logic [127:0] num, den, q;
    @(negedge clk);
    mode = m; a_freq = a; b_freq = b; old_mult = mult; old_hs = hs; old_n1 = n1; start = 1;
    num = m ? 128'(a) * 128'(hs) * 128'(n1) : 128'(a);
    den = m ? 128'(mult) : 128'(b);
    if (den == 0) begin
      q_res.push_back('0); q_flg.push_back(2'b01);
    end else begin
      q = (num << FRAC) / den;
      if (q >= (128'd1 << RW)) begin
        q_res.push_back('1); q_flg.push_back(2'b10);
      end else begin
        q_res.push_back(q[RW-1:0]); q_flg.push_back(2'b00);
      end
    end
    q_due.push_back(cyc + 1 + RW);
    q_req.push_back(req);
    @(negedge clk);
    start = 0;
    a_freq = ~a; b_freq = ~b; old_mult = ~mult; old_hs = ~hs; old_n1 = ~n1; mode = ~m; // R7 capture
  endtask

  task automatic wait_idle();
    while (q_res.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_res.size() == 0) begin
        checks++; fails++;
        $display("FAIL R7 actual=unexpected done expected=no done");
      end else begin
        string r;
        r = q_req.pop_front();
        check({r, " result"}, 64'(result), 64'(q_res.pop_front()));
        check({r, " flags"}, {62'd0, overflow, div_zero}, 64'(q_flg.pop_front()));
        check("R4 latency", 64'(cyc), 64'(q_due.pop_front()));
        check("R4 busy low at done", 64'(busy), 64'd0);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [RW-1:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R9 busy", 64'(busy), 0);
    check("R9 done", 64'(done), 0);
    check("R9 result", 64'(result), 0);
    check("R9 flags", {62'd0, overflow, div_zero}, 0);

    run("R1 example", 0, 36'd4354587216, 36'd100000000, '0, '0, '0);
    wait_idle();
    check("R1 literal", 64'(result), 64'h02B8BBE472);

    run("R2 integer ratio", 0, 36'd5000000000, 36'd125000000, '0, '0, '0);
    wait_idle();
    check("R2 literal 40", 64'(result), 64'(40) << FRAC);
    run("R2 small ratio", 0, 36'd3, 36'd7, '0, '0, '0);
    wait_idle();

    run("R3 recovery", 1, 36'd156250000, '0, 38'h02B8BBE472, 4'd4, 7'd8);
    wait_idle();
    run("R3 recovery b", 1, 36'd100000, '0, 38'h0011000000, 4'd11, 7'd64);
    wait_idle();

    run("R5 just below", 0, 36'd1023999, 36'd1000, '0, '0, '0);
    wait_idle();
    check("R5 no overflow", 64'(overflow), 0);
    run("R5 exact limit", 0, 36'd1024000, 36'd1000, '0, '0, '0);
    wait_idle();
    run("R5 mode1 overflow", 1, 36'd100, '0, 38'd1, 4'd4, 7'd8);
    wait_idle();

    run("R6 zero mode0", 0, 36'd12345, 36'd0, '0, '0, '0);
    wait_idle();
    run("R6 zero mode1", 1, 36'd12345, '0, '0, 4'd4, 7'd2);
    wait_idle();

    run("R7 busy start", 0, 36'd900, 36'd7, '0, '0, '0);
    repeat (5) @(negedge clk);
    check("R7 busy mid-run", 64'(busy), 1);
    start = 1; a_freq = 36'd1; b_freq = 36'd0;
    @(negedge clk);
    start = 0;
    wait_idle();
    repeat (45) @(negedge clk);

    run("R2 back to back", 0, 36'd777777, 36'd3333, '0, '0, '0);
    wait_idle();
    held = result;
    a_freq = 36'd5; b_freq = 36'd0;
    repeat (20) @(negedge clk);
    check("R8 hold result", 64'(result), 64'(held));
    check("R8 hold flags", {62'd0, overflow, div_zero}, 0);

    finish_run();
  end
endmodule